// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and a 1024-word by 4-bit asynchronous static RAM. The host hands over one word access at a time through a valid/ready handshake. Each request carries a write flag, a 10-bit word address and 4 bits of write data. The controller turns the request into the chip-enable, write-enable and data-bus sequence the memory expects. When the access is over, it pulses a done flag. For reads, it also presents the captured word.

Every minimum timing interval of the memory is given as a parameter in whole clock cycles: read access, write pulse, data setup before the end of the write, and bus turnaround after a write. Each one is the nanosecond figure divided by the clock period and rounded up, with a minimum of one cycle.

Address setup and hold are both zero. Address and data are therefore launched in the same cycle that chip enable falls. All pins to the memory come straight from flip-flops. The shared data bus is split into a driven value, a sampled value and an output enable, and the pad logic joins them.

Top module: `async_sram_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the pins are: `mem_ce_no`=1, `mem_we_no`=1, `mem_dq_oe_o`=0, `req_ready_o`=1 and `rsp_done_o`=0.
- R2: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 from the cycle after that edge until the access, and any turnaround that follows it, is complete.
- R3: A read (`req_write_i`=0) holds `mem_ce_no`=0 and `mem_we_no`=1 for exactly ACC_CYC cycles. Throughout those cycles `mem_dq_oe_o`=0.
- R4: A read samples `mem_dq_i` at the edge that ends the last access cycle. `rsp_done_o` is 1 for exactly one cycle, the (ACC_CYC+1)-th cycle after the accepting edge. During that cycle `rsp_rdata_o` holds the sampled word, and it keeps holding it until the next read completes.
- R5: A write (`req_write_i`=1) holds `mem_ce_no`=0, `mem_we_no`=0 and `mem_dq_oe_o`=1 for exactly max(WP_CYC, DW_CYC) cycles. During those cycles `mem_dq_o` equals the request's write data.
- R6: At the end of a write, `mem_we_no` and `mem_ce_no` return to 1 in the same cycle, and `mem_dq_oe_o` returns to 0 in that cycle as well. `rsp_done_o` is 1 in that cycle and only in that cycle.
- R7: After a write's done cycle, `req_ready_o` stays 0 for TURN_CYC cycles counted from the done cycle. It returns to 1 in the cycle after those.
- R8: While `mem_ce_no`=0, `mem_addr_o` equals the address of the request being served and does not change.
- R9: A write leaves `rsp_rdata_o` unchanged.
- R10: `mem_dq_oe_o` is never 1 while `mem_ce_no`=0 and `mem_we_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Last word read |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_dq_o | output | DATA_W | Value driven onto the data bus |
| mem_dq_i | input | DATA_W | Value sampled from the data bus |
| mem_dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench is built with ACC_CYC=3, WP_CYC=2, DW_CYC=3 and TURN_CYC=2, so the write pulse is stretched by the data setup time. Counted from the accepting edge, a read's done pulse is due in cycle 4 and a write's done pulse in cycle 4 as well. After a write, ready is due back 2 cycles after its done cycle.

All outputs are sampled at falling clock edges, and the bench counts those edges from the accepting rising edge. That count is the measured latency, and it must equal the figure above. Over the same window the bench counts how many cycles chip enable and write enable are low.

The bench's memory model returns the inverse of the stored word until chip enable has been low for ACC_CYC cycles. A capture made one cycle early would therefore return wrong data. Two passes, one in ascending and one in descending order, write and then read back all 1024 addresses, comparing against patterns computed from the address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2,
    SEQ_TURN = 2'd3
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       write_i,
  input  logic       last_i,
  output logic       idle_o,
  output logic       finish_rd_o,
  output logic       finish_wr_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (accept_i) state_d = write_i ? SEQ_WR : SEQ_RD;
      SEQ_RD:   if (last_i)   state_d = SEQ_IDLE;
      SEQ_WR:   if (last_i)   state_d = SEQ_TURN;
      SEQ_TURN: if (last_i)   state_d = SEQ_IDLE;
      default:                state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o      = (state_q == SEQ_IDLE);
  assign finish_rd_o = (state_q == SEQ_RD) && last_i;
  assign finish_wr_o = (state_q == SEQ_WR) && last_i;

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RD || state_q == SEQ_WR) && !last_i |=> !idle_o);
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 4,
  parameter int ACC_CYC  = 1,
  parameter int WP_CYC   = 1,
  parameter int DW_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  // write pulse must also cover data setup before its end
  localparam int WPX_CYC = imax(WP_CYC, DW_CYC);
  localparam int MAX_CYC = imax(imax(ACC_CYC, WPX_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WPX_LD  = CNT_W'(WPX_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  logic             idle, last, finish_rd, finish_wr, accept, load;
  logic [CNT_W-1:0] load_val;

  assign accept      = req_valid_i && idle;
  assign req_ready_o = idle;
  assign load        = accept || finish_wr;
  assign load_val    = finish_wr ? TURN_LD : (req_write_i ? WPX_LD : ACC_LD);

  sram_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .write_i     (req_write_i),
    .last_i      (last),
    .idle_o      (idle),
    .finish_rd_o (finish_rd),
    .finish_wr_o (finish_wr)
  );

  sram_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o  <= '0;
      mem_dq_o    <= '0;
      mem_ce_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_dq_oe_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_done_o  <= 1'b0;
    end else begin
      rsp_done_o <= 1'b0;
      if (accept) begin
        mem_addr_o  <= req_addr_i;
        mem_dq_o    <= req_wdata_i;
        mem_ce_no   <= 1'b0;
        mem_we_no   <= !req_write_i;
        mem_dq_oe_o <= req_write_i;
      end
      if (finish_rd) begin
        rsp_rdata_o <= mem_dq_i;
        mem_ce_no   <= 1'b1;
        rsp_done_o  <= 1'b1;
      end
      if (finish_wr) begin
        mem_ce_no   <= 1'b1;
        mem_we_no   <= 1'b1;
        mem_dq_oe_o <= 1'b0;
        rsp_done_o  <= 1'b1;
      end
    end
  end

  // R8
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no && $past(!mem_ce_no) |-> $stable(mem_addr_o) && $stable(mem_dq_o));
  // R10
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_ce_no && mem_we_no));
  // R5
  we_inside_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no && mem_dq_oe_o);
  // R6
  we_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_ce_no && !mem_dq_oe_o && rsp_done_o);
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  // R2
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !req_ready_o);
  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |=> $stable(rsp_rdata_o));
endmodule

// File: tb/sim_async_sram_ctrl.sv
`timescale 1ns/1ps
module sim_async_sram_ctrl;
  localparam int ACC  = 3;
  localparam int WP   = 2;
  localparam int DW   = 3;
  localparam int TURN = 2;
  localparam int WPX  = (WP > DW) ? WP : DW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic       ready, done, ce_n, we_n, dq_oe;
  logic [3:0] rdata, dq_out, dq_in;
  logic [9:0] mem_addr;

  int checks = 0;
  int errors = 0;
  logic [3:0] model [1024];
  int acc_cnt = 0;

  always #10 clk = ~clk;

  async_sram_ctrl #(
    .ADDR_W(10), .DATA_W(4), .ACC_CYC(ACC), .WP_CYC(WP), .DW_CYC(DW), .TURN_CYC(TURN)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(done), .rsp_rdata_o(rdata),
    .mem_addr_o(mem_addr), .mem_ce_no(ce_n), .mem_we_no(we_n),
    .mem_dq_o(dq_out), .mem_dq_i(dq_in), .mem_dq_oe_o(dq_oe)
  );

  // memory model: data valid only after ACC cycles of read enable
  always @(negedge clk) begin
    if (!ce_n && !we_n && dq_oe) model[mem_addr] = dq_out;
    if (!ce_n && we_n) acc_cnt = acc_cnt + 1;
    else acc_cnt = 0;
    if (dq_oe && !ce_n && we_n) begin
      checks++; errors++;
      $display("FAIL R10: bus driven during read, oe=%0d expected 0", dq_oe);
    end
  end
  assign dq_in = (acc_cnt >= ACC) ? model[mem_addr] : ~model[mem_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int a, input int pass);
    return 4'((a ^ (a >> 4) ^ (a >> 8) ^ (pass * 5)) & 15);
  endfunction

  task automatic do_op(input bit wr, input int a, input logic [3:0] d, input logic [3:0] exp_rd);
    int n, ce_cnt, we_cnt, t;
    logic [3:0] prev_rd;
    @(negedge clk);
    chk(ready == 1'b1, "R2", ready, 1);
    prev_rd = rdata;
    req_valid = 1'b1; req_write = wr; req_addr = 10'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(ready == 1'b0, "R2", ready, 0);
    n = 1; ce_cnt = 0; we_cnt = 0;
    while (!done && n < 64) begin
      if (!ce_n) begin
        ce_cnt++;
        chk(mem_addr == 10'(a), "R8", mem_addr, a);
        if (wr) chk(dq_out == d && dq_oe, "R5", dq_out, d);
        else    chk(!dq_oe && we_n, "R3", dq_oe, 0);
      end
      if (!we_n) we_cnt++;
      @(negedge clk);
      n++;
    end
    if (wr) begin
      chk(n == WPX + 1, "R6", n, WPX + 1);
      chk(ce_cnt == WPX, "R5", ce_cnt, WPX);
      chk(we_cnt == WPX, "R5", we_cnt, WPX);
      chk(ce_n && we_n && !dq_oe, "R6", {ce_n, we_n, dq_oe}, 6);
      chk(rdata == prev_rd, "R9", rdata, prev_rd);
      chk(ready == 1'b0, "R7", ready, 0);
      t = 0;
      while (!ready && t < 64) begin
        @(negedge clk);
        t++;
        if (t == 1) chk(done == 1'b0, "R6", done, 0);
      end
      chk(t == TURN, "R7", t, TURN);
    end else begin
      chk(n == ACC + 1, "R4", n, ACC + 1);
      chk(ce_cnt == ACC, "R3", ce_cnt, ACC);
      chk(we_cnt == 0, "R3", we_cnt, 0);
      chk(rdata == exp_rd, "R4", rdata, exp_rd);
      chk(ready == 1'b1, "R2", ready, 1);
      @(negedge clk);
      chk(done == 1'b0, "R4", done, 0);
      chk(rdata == exp_rd, "R4", rdata, exp_rd);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = 4'(i * 7);
    #35;
    // R1: reset state
    chk(ce_n && we_n && !dq_oe, "R1", {ce_n, we_n, dq_oe}, 6);
    chk(ready && !done, "R1", {ready, done}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && we_n && !dq_oe && ready && !done, "R1", {ce_n, we_n, dq_oe, ready, done}, 26);
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 1024; i++) begin
        int a = (pass == 0) ? i : 1023 - i;
        do_op(1'b1, a, pat(a, pass), 4'h0);
      end
      for (int i = 0; i < 1024; i++) begin
        int a = (pass == 0) ? i : 1023 - i;
        do_op(1'b0, a, 4'h0, pat(a, pass));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule